// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block is the multiply and divide engine of a 32-bit CPU core. The core hands it an accumulator operand, a second operand and a 2-bit operation code, then pulses `start`. The unit works on operand magnitudes, one bit per cycle, and then corrects the signs. It returns a primary result meant for the accumulator and a secondary result meant for an auxiliary register. For a multiply, the primary result is the low half of the double-width product and the secondary result is the high half. For a divide, the primary result is the quotient and the secondary result is the remainder.

The core is responsible for fetching operands and writing registers back. The unit only gives the handshake: `busy` while a job runs, then a single-cycle `done`. When `done` is high the results are valid, and they stay held until the next job completes. A division by zero finishes with a defined result and raises a flag in the same cycle as `done`.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 is a signed multiply; `acc_result` is the low W bits of the two's-complement product.
- R2: Operation code 2'b01 is an unsigned multiply; `acc_result` is the low W bits of the unsigned product.
- R3: For both multiplies, `aux_result` is the high W bits of the 2W-bit product, as its raw bit pattern with no further extension.
- R4: Operation code 2'b10 is a signed divide. The quotient goes to `acc_result` and truncates toward zero. The remainder goes to `aux_result` and takes the sign of the dividend. The one overflowing case, the most negative value divided by -1, wraps to quotient 0x80000000 with remainder 0.
- R5: Operation code 2'b11 is an unsigned divide, with the quotient on `acc_result` and the remainder on `aux_result`.
- R6: A divide whose second operand is zero gives an all-ones `acc_result` and the dividend unchanged on `aux_result`, and raises `div_zero` in the same cycle as `done`.
- R7: A `start` sampled while idle latches both operands and the operation. `busy` is then high for W+1 cycles (W iterations plus one sign fix-up). `done` follows as a one-cycle pulse with `busy` low.
- R8: A `start` sampled while `busy` is high has no effect on the running job or on its results.
- R9: After reset all outputs are zero. `acc_result` and `aux_result` change only in a cycle where `done` is high.
- R10: `div_zero` stays low for every multiply and for every divide with a non-zero second operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation; sampled only while idle |
| op | input | 2 | Operation code (see R1, R2, R4, R5) |
| opnd_a | input | W | Accumulator operand (multiplicand or dividend) |
| opnd_b | input | W | Second operand (multiplier or divisor) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divide-by-zero flag, valid with done |
| acc_result | output | W | Low product half or quotient |
| aux_result | output | W | High product half or remainder |

## Verification
On every cycle the embedded assertions check the handshake. `done` is a one-cycle pulse that never overlaps `busy`, and an accepted start raises `busy`. A start while busy leaves the latched job untouched, the results hold between completions, and `div_zero` appears only together with `done`. Inside the datapath, the partial remainder is checked to stay below a non-zero divisor. The numeric results can only be shown by the bench's scenarios. These cover mixed-sign products, the all-ones operands, truncation of negative quotients, the overflowing signed divide, divides by zero in both signednesses, a start issued mid-job, and a new job accepted in the same cycle as `done`.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [1:0] {
        OP_SMUL = 2'b00,
        OP_UMUL = 2'b01,
        OP_SDIV = 2'b10,
        OP_UDIV = 2'b11
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ITER = 2'b01,
        ST_FIX  = 2'b10
    } mdu_state_e;

    // Sign and mode information carried from operand prep to result fix-up
    typedef struct packed {
        logic is_div;
        logic neg_lo;   // negate product (mul) or quotient (div)
        logic neg_hi;   // negate remainder (div only)
        logic dz;       // divisor is zero
    } mdu_fix_t;

    function automatic logic op_is_div(mdu_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_signed(mdu_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/mdu_prep.sv
module mdu_prep
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  mdu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   mag_a,
    output logic [W-1:0]   mag_b,
    output mdu_fix_t       fix
);
    logic sgn_a;
    logic sgn_b;

    always_comb begin
        sgn_a = op_is_signed(op) & a[W-1];
        sgn_b = op_is_signed(op) & b[W-1];
        mag_a = sgn_a ? (~a + 1'b1) : a;
        mag_b = sgn_b ? (~b + 1'b1) : b;
        fix.is_div = op_is_div(op);
        fix.neg_lo = sgn_a ^ sgn_b;
        fix.neg_hi = op_is_div(op) ? sgn_a : (sgn_a ^ sgn_b);
        fix.dz     = op_is_div(op) & (b == '0);
    end
endmodule

// File: rtl/mdu_iter.sv
module mdu_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic           is_div,
    input  logic [W-1:0]   mag_a,
    input  logic [W-1:0]   mag_b,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);
    logic [W-1:0] opnd_q;
    logic         div_q;
    logic [W:0]   mul_sum;
    logic [W:0]   rem_sh;
    logic [W:0]   rem_diff;

    always_comb begin
        mul_sum  = {1'b0, hi} + (lo[0] ? {1'b0, opnd_q} : '0);
        rem_sh   = {hi, lo[W-1]};
        rem_diff = rem_sh - {1'b0, opnd_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi     <= '0;
            lo     <= '0;
            opnd_q <= '0;
            div_q  <= 1'b0;
        end else if (load) begin
            hi     <= '0;
            lo     <= is_div ? mag_a : mag_b;
            opnd_q <= is_div ? mag_b : mag_a;
            div_q  <= is_div;
        end else if (step) begin
            if (div_q) begin
                if (!rem_diff[W]) begin
                    hi <= rem_diff[W-1:0];
                    lo <= {lo[W-2:0], 1'b1};
                end else begin
                    hi <= rem_sh[W-1:0];
                    lo <= {lo[W-2:0], 1'b0};
                end
            end else begin
                hi <= mul_sum[W:1];
                lo <= {mul_sum[0], lo[W-1:1]};
            end
        end
    end

    // R4 / R5: restoring division keeps the partial remainder below the divisor
    a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (div_q && opnd_q != '0) |-> (hi < opnd_q));
endmodule

// File: rtl/mdu_fix.sv
module mdu_fix
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   dividend,
    input  mdu_fix_t       fix,
    output logic [W-1:0]   acc,
    output logic [W-1:0]   aux
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [PW-1:0] prod_neg;

    always_comb begin
        prod     = {hi, lo};
        prod_neg = ~prod + 1'b1;
        if (!fix.is_div) begin
            acc = fix.neg_lo ? prod_neg[W-1:0]  : lo;
            aux = fix.neg_lo ? prod_neg[PW-1:W] : hi;
        end else if (fix.dz) begin
            acc = '1;
            aux = dividend;
        end else begin
            acc = fix.neg_lo ? (~lo + 1'b1) : lo;
            aux = fix.neg_hi ? (~hi + 1'b1) : hi;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic           busy,
    output logic           done,
    output logic           div_zero,
    output logic [W-1:0]   acc_result,
    output logic [W-1:0]   aux_result
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mdu_state_e    state_q;
    logic [CW-1:0] cnt_q;
    mdu_fix_t      fix_d;
    mdu_fix_t      fix_q;
    logic [W-1:0]  dvd_q;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic [W-1:0]  hi;
    logic [W-1:0]  lo;
    logic [W-1:0]  acc_d;
    logic [W-1:0]  aux_d;
    logic          accept;

    assign busy   = (state_q != ST_IDLE);
    assign accept = start & ~busy;

    mdu_prep #(.W(W)) u_prep (
        .op    (mdu_op_e'(op)),
        .a     (opnd_a),
        .b     (opnd_b),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .fix   (fix_d)
    );

    mdu_iter #(.W(W)) u_iter (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (state_q == ST_ITER),
        .is_div (fix_d.is_div),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .hi     (hi),
        .lo     (lo)
    );

    mdu_fix #(.W(W)) u_fix (
        .hi       (hi),
        .lo       (lo),
        .dividend (dvd_q),
        .fix      (fix_q),
        .acc      (acc_d),
        .aux      (aux_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            fix_q      <= '0;
            dvd_q      <= '0;
            done       <= 1'b0;
            div_zero   <= 1'b0;
            acc_result <= '0;
            aux_result <= '0;
        end else begin
            done     <= 1'b0;
            div_zero <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_ITER;
                        cnt_q   <= '0;
                        fix_q   <= fix_d;
                        dvd_q   <= opnd_a;
                    end
                end
                ST_ITER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    state_q    <= ST_IDLE;
                    done       <= 1'b1;
                    div_zero   <= fix_q.dz;
                    acc_result <= acc_d;
                    aux_result <= aux_d;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: done and busy never overlap
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R7: an idle start launches a job
    a_r7_start_to_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R8: a start during a job leaves the latched job unchanged
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> ($stable(fix_q) && $stable(dvd_q)));
    // R9: results hold between completions
    a_r9_results_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(acc_result) && $stable(aux_result)));
    // R6 / R10: the divide-by-zero flag only accompanies done
    a_r6_dz_with_done: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> done);
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic          busy;
    logic          done;
    logic          div_zero;
    logic [W-1:0]  acc_result;
    logic [W-1:0]  aux_result;

    always #4 clk = ~clk;   // 125 MHz

    muldiv_unit #(.W(W)) u_muldiv_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy), .done(done), .div_zero(div_zero),
        .acc_result(acc_result), .aux_result(aux_result)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit armed = 1'b0;

    // behavioural reference model
    bit          m_busy = 0, m_done = 0, m_dz = 0, m_ign = 0, m_job_ign = 0;
    int          m_left = 0;
    logic [1:0]  m_op = 0;
    logic [31:0] m_a = 0, m_b = 0, m_acc = 0, m_aux = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compute();
        logic signed [63:0] sa, sb, q, r;
        logic [63:0] p;
        sa = {{32{m_a[31]}}, m_a};
        sb = {{32{m_b[31]}}, m_b};
        m_dz = 0;
        case (m_op)
            2'b00: begin p = sa * sb; m_acc = p[31:0]; m_aux = p[63:32]; end
            2'b01: begin p = {32'b0, m_a} * {32'b0, m_b}; m_acc = p[31:0]; m_aux = p[63:32]; end
            2'b10: begin
                if (m_b == 0) begin m_acc = '1; m_aux = m_a; m_dz = 1; end
                else begin q = sa / sb; r = sa % sb; m_acc = q[31:0]; m_aux = r[31:0]; end
            end
            default: begin
                if (m_b == 0) begin m_acc = '1; m_aux = m_a; m_dz = 1; end
                else begin m_acc = m_a / m_b; m_aux = m_a % m_b; end
            end
        endcase
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_acc = 0; m_aux = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (start) m_ign = 1;
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_job_ign = m_ign;
                    compute();
                end
            end else begin
                m_dz = 0;
                if (start) begin
                    m_busy = 1; m_left = W + 1; m_ign = 0;
                    m_op = op; m_a = opnd_a; m_b = opnd_b;
                end
            end
        end
        armed = 1'b1;
    end

    function automatic string acc_tag();
        if (m_job_ign) return "R8";
        case (m_op)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return (m_b == 0) ? "R6" : "R4";
            default: return (m_b == 0) ? "R6" : "R5";
        endcase
    endfunction

    function automatic string aux_tag();
        if (m_job_ign) return "R8";
        if (!m_op[1]) return "R3";
        if (m_b == 0) return "R6";
        return m_op[0] ? "R5" : "R4";
    endfunction

    always @(negedge clk) begin
        if (armed && !rst) begin
            chk("R7 busy", {63'b0, busy}, {63'b0, m_busy});
            chk("R7 done", {63'b0, done}, {63'b0, m_done});
            if (m_done) begin
                chk(acc_tag(), {32'b0, acc_result}, {32'b0, m_acc});
                chk(aux_tag(), {32'b0, aux_result}, {32'b0, m_aux});
                chk(m_dz ? "R6 flag" : "R10 flag", {63'b0, div_zero}, {63'b0, m_dz});
            end else begin
                chk("R9 hold", {acc_result, aux_result}, {m_acc, m_aux});
                chk("R10 flag idle", {63'b0, div_zero}, 64'b0);
            end
        end
    end

    task automatic launch(logic [1:0] o, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = o; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(logic [1:0] o, logic [31:0] a, logic [31:0] b);
        launch(o, a, b);
        repeat (W + 2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset", {busy, done, div_zero}, 3'b0);
        chk("R9 reset results", {acc_result, aux_result}, 64'b0);
        rst = 1'b0;

        run(2'b00, 32'hFFFF_FFF9, 32'd6);           // R1 -7*6
        run(2'b00, 32'h8000_0000, 32'h8000_0000);   // R1 R3 most negative squared
        run(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R1 -1*-1
        run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R2 R3
        run(2'b01, 32'h1234_5678, 32'h9ABC_DEF0);   // R2 R3
        run(2'b10, 32'hFFFF_FFF9, 32'd2);           // R4 -7/2
        run(2'b10, 32'd7, 32'hFFFF_FFFE);           // R4 7/-2
        run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);   // R4 overflow wrap
        run(2'b11, 32'hFFFF_FFFF, 32'd10);          // R5
        run(2'b11, 32'd5, 32'd9);                   // R5 quotient zero
        run(2'b10, 32'hFFFF_FF00, 32'd0);           // R6 signed
        run(2'b11, 32'h0000_BEEF, 32'd0);           // R6 unsigned

        // R8: start issued mid-job with different operands
        launch(2'b01, 32'd1000, 32'd3);
        repeat (5) @(negedge clk);
        start = 1'b1; op = 2'b11; opnd_a = 32'd77; opnd_b = 32'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (W) @(negedge clk);

        // R7: new job accepted in the cycle done is high
        launch(2'b11, 32'd100, 32'd7);
        repeat (W + 1) @(negedge clk);
        start = 1'b1; op = 2'b00; opnd_a = 32'd12; opnd_b = 32'hFFFF_FFFD;
        @(negedge clk);
        start = 1'b0;
        repeat (W + 3) @(negedge clk);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule